// File: doc/BRIEF.md
# Serial Configuration Register Bank with Frame-Aligned Commit

This block is the write-only configuration port of a camera analog front end. A host shifts 16-bit words into it over three wires: a serial clock, a serial data line and an enable strobe. Each word carries a 4-bit address, most significant bit first, followed by 12 data bits, also most significant bit first. When the strobe falls after exactly 16 clocked bits, the word is decoded. It then updates one of five staging registers: amplifier gain code, auxiliary converter code, clamp reference level, control word and test word.

Staged values reach the parallel outputs only on an edge of the frame sync input, so a setting never changes part way through a frame. Bit 8 of the active control word selects which edge is used. A special initialization word restores every register to its default at once, without waiting for sync. When no frame sync exists, the strobe can be wired to the sync input. With the falling edge selected, each write then takes effect at the end of its own strobe. All serial and sync inputs are asynchronous to the system clock and are brought in through synchronizers.

Top module: `cfg_serial_bank`

## Requirements
- R1: After reset, gain, auxiliary, clamp and test outputs are 0 and the control word is 12'h2C4 (bits 2, 6, 7 and 9 set).
- R2: While the strobe is high, one bit is taken from the data line on each rising edge of the serial clock. The first four bits are the address (MSB first) and the next twelve are the data (MSB first). The word is accepted on the falling edge of the strobe.
- R3: Address 0 loads the gain code from data[7:0]. Address 1 loads the auxiliary code from data[7:0]. Address 2 loads the clamp code from data[6:0]. Address 3 loads the control word from data[11:0]. Address 15 loads the test word from data[11:0]. Data bits above a field's width are dropped.
- R4: An accepted write changes no output until a frame sync edge. When control bit 8 of the active word is 0, the rising sync edge applies all staged values. When it is 1, the falling edge applies them. The other edge has no effect.
- R5: A change of control bit 8 selects the new sync edge only after that control word has itself been applied by a sync edge.
- R6: A word with address 4 and data exactly 12'h100 returns all staged and active registers to their R1 defaults within a few clocks, with no sync edge, and discards pending writes. Address 4 with any other data is ignored.
- R7: Words to addresses 5 through 14 change neither the staged nor the active registers.
- R8: A strobe that ends after fewer or more than 16 clocked bits changes no register.
- R9: A second write to the same address before a sync edge replaces the first, and only the last value is applied.
- R10: With the strobe wired to the sync input and control bit 8 set, each write is visible on the outputs right after its own strobe ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_strobe | input | 1 | Word enable strobe, high while shifting |
| frame_sync | input | 1 | Frame sync, asynchronous |
| gain_code | output | 8 | Active amplifier gain code |
| aux_code | output | 8 | Active auxiliary converter code |
| clamp_code | output | 7 | Active clamp reference code |
| ctrl_word | output | 12 | Active control and polarity word |
| test_word | output | 12 | Active test mode word |

## Verification
A corrupted staging register stays hidden until the next sync edge applies it, so the bench checks all outputs at both halves of every sync pulse. A value that reaches the outputs early shows up at the first check after the rising edge. A wrong edge select shows up as a commit that is missing or late by half a pulse. A bad bit count or a bad shift order produces a wrong or missing value on the first sweep word that follows. A faulty initialization shows up within a dozen clocks of the strobe falling, with no sync edge involved.

// File: rtl/cfg_bank_pkg.sv
// Shared constants and per-slot descriptions for the serial configuration bank.
// Assumes five register slots in a fixed order: gain, aux, clamp, ctrl, test.
package cfg_bank_pkg;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 12;
    localparam int WORD_W    = ADDR_W + DATA_W;
    localparam int NUM_SLOTS = 5;

    localparam logic [ADDR_W-1:0] ADDR_GAIN  = 4'd0;
    localparam logic [ADDR_W-1:0] ADDR_AUX   = 4'd1;
    localparam logic [ADDR_W-1:0] ADDR_CLAMP = 4'd2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 4'd3;
    localparam logic [ADDR_W-1:0] ADDR_INIT  = 4'd4;
    localparam logic [ADDR_W-1:0] ADDR_TEST  = 4'd15;

    localparam logic [DATA_W-1:0] INIT_KEY     = 12'h100;
    localparam logic [DATA_W-1:0] CTRL_DEFAULT = 12'h2C4;
    localparam int                EDGE_SEL_BIT = 8;

    localparam int SLOT_GAIN = 0;
    localparam int SLOT_CTRL = 3;

    // Address decoded by each slot.
    function automatic logic [ADDR_W-1:0] slot_addr(input int s);
        case (s)
            0:       return ADDR_GAIN;
            1:       return ADDR_AUX;
            2:       return ADDR_CLAMP;
            3:       return ADDR_CTRL;
            default: return ADDR_TEST;
        endcase
    endfunction

    // Number of data bits each slot keeps.
    function automatic int slot_width(input int s);
        case (s)
            0, 1:    return 8;
            2:       return 7;
            default: return DATA_W;
        endcase
    endfunction

    // Mask of kept bits, derived from the width.
    function automatic logic [DATA_W-1:0] slot_mask(input int s);
        return DATA_W'((1 << slot_width(s)) - 1);
    endfunction

    // Reset and initialization value of each slot.
    function automatic logic [DATA_W-1:0] slot_default(input int s);
        return (s == SLOT_CTRL) ? CTRL_DEFAULT : '0;
    endfunction

    // All defaults packed with slot 0 in the low bits.
    function automatic logic [NUM_SLOTS*DATA_W-1:0] all_defaults();
        logic [NUM_SLOTS*DATA_W-1:0] v;
        for (int s = 0; s < NUM_SLOTS; s++) v[s*DATA_W +: DATA_W] = slot_default(s);
        return v;
    endfunction
endpackage

// File: rtl/cfg_sync_edge.sv
// Multi-flop synchronizer with rise/fall detection for a vector of
// asynchronous inputs. Assumes inputs are held for several clocks.
module cfg_sync_edge #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prev_q;

    // First stage captures the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= async_in;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            // Later stages settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    // Delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev_q;
    assign fall  = ~chain[STAGES-1] & prev_q;
endmodule

// File: rtl/cfg_word_shifter.sv
// Shifts serial bits in MSB first while the strobe is high and flags a word
// when the strobe falls after exactly WORD_W bits. Assumes synchronized inputs.
module cfg_word_shifter #(
    parameter int WORD_W = 16,
    localparam int CAP   = WORD_W + 1,
    localparam int CNT_W = $clog2(WORD_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_lvl,
    input  logic              sclk_rise,
    input  logic              strobe_lvl,
    input  logic              strobe_rise,
    input  logic              strobe_fall,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_q,
    output logic [CNT_W-1:0]  bit_cnt
);
    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;

    // Shift register and saturating bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (strobe_rise) begin
            cnt_q <= '0;
        end else if (strobe_lvl && sclk_rise) begin
            shreg_q <= {shreg_q[WORD_W-2:0], data_lvl};
            if (cnt_q != CNT_W'(CAP)) cnt_q <= cnt_q + 1'b1;
        end
    end

    // A word is valid only when the strobe ends on a full count.
    always_comb word_valid = strobe_fall && (cnt_q == CNT_W'(WORD_W));

    assign word_q  = shreg_q;
    assign bit_cnt = cnt_q;
endmodule

// File: rtl/cfg_reg_file.sv
// Decodes accepted words into per-slot staging registers and copies staged
// values to active registers on commit. Initialization overrides both.
// Assumes at most one word per clock.
module cfg_reg_file
    import cfg_bank_pkg::*;
#(
    parameter int SLOTS = NUM_SLOTS,
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [AW-1:0]     word_addr,
    input  logic [DW-1:0]     word_data,
    input  logic              commit,
    output logic [SLOTS*DW-1:0] stage_flat,
    output logic [SLOTS*DW-1:0] active_flat,
    output logic [SLOTS-1:0]  wr_hit,
    output logic              init_hit
);
    // Initialization word detect.
    always_comb init_hit = word_valid && (word_addr == ADDR_INIT) && (word_data == INIT_KEY);

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            localparam logic [DW-1:0] MASK = slot_mask(s);
            localparam logic [DW-1:0] DEF  = slot_default(s);
            logic [DW-1:0] stage_q, active_q, stage_nx;

            // Address match for this slot.
            always_comb wr_hit[s] = word_valid && (word_addr == slot_addr(s));

            // Next staged value with the same-cycle write forwarded.
            always_comb stage_nx = wr_hit[s] ? (word_data & MASK) : stage_q;

            // Staging and active registers.
            always_ff @(posedge clk) begin
                if (!rst_n || init_hit) begin
                    stage_q  <= DEF;
                    active_q <= DEF;
                end else begin
                    stage_q <= stage_nx;
                    if (commit) active_q <= stage_nx;
                end
            end

            assign stage_flat[s*DW +: DW]  = stage_q;
            assign active_flat[s*DW +: DW] = active_q;
        end
    endgenerate
endmodule

// File: rtl/cfg_serial_bank.sv
// Top of the serial configuration bank: synchronizes the three-wire port and
// frame sync, assembles words, and commits staged values on the selected
// sync edge. Assumes serial clock period of several system clocks.
module cfg_serial_bank
    import cfg_bank_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(WORD_W + 2)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_clk,
    input  logic        ser_data,
    input  logic        ser_strobe,
    input  logic        frame_sync,
    output logic [7:0]  gain_code,
    output logic [7:0]  aux_code,
    output logic [6:0]  clamp_code,
    output logic [11:0] ctrl_word,
    output logic [11:0] test_word
);
    localparam int IDX_DATA = 0;
    localparam int IDX_SCLK = 1;
    localparam int IDX_STB  = 2;
    localparam int IDX_VS   = 3;

    logic [3:0] s_lvl, s_rise, s_fall;
    logic       word_valid;
    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic       commit;
    logic       init_hit;
    logic [NUM_SLOTS-1:0]        wr_hit;
    logic [NUM_SLOTS*DATA_W-1:0] stage_flat, active_flat;
    logic       sync_unused;

    cfg_sync_edge #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({frame_sync, ser_strobe, ser_clk, ser_data}),
        .level    (s_lvl),
        .rise     (s_rise),
        .fall     (s_fall)
    );

    cfg_word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_lvl    (s_lvl[IDX_DATA]),
        .sclk_rise   (s_rise[IDX_SCLK]),
        .strobe_lvl  (s_lvl[IDX_STB]),
        .strobe_rise (s_rise[IDX_STB]),
        .strobe_fall (s_fall[IDX_STB]),
        .word_valid  (word_valid),
        .word_q      (word_q),
        .bit_cnt     (bit_cnt)
    );

    // Commit on the sync edge chosen by the active control word.
    always_comb commit = ctrl_word[EDGE_SEL_BIT] ? s_fall[IDX_VS] : s_rise[IDX_VS];

    cfg_reg_file #(.SLOTS(NUM_SLOTS), .DW(DATA_W), .AW(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_valid  (word_valid),
        .word_addr   (word_q[WORD_W-1 -: ADDR_W]),
        .word_data   (word_q[DATA_W-1:0]),
        .commit      (commit),
        .stage_flat  (stage_flat),
        .active_flat (active_flat),
        .wr_hit      (wr_hit),
        .init_hit    (init_hit)
    );

    // Map active slots onto the output fields.
    assign gain_code  = active_flat[0*DATA_W +: 8];
    assign aux_code   = active_flat[1*DATA_W +: 8];
    assign clamp_code = active_flat[2*DATA_W +: 7];
    assign ctrl_word  = active_flat[3*DATA_W +: DATA_W];
    assign test_word  = active_flat[4*DATA_W +: DATA_W];

    // Edge and level outputs and masked bits that no logic consumes.
    assign sync_unused = ^{s_lvl[IDX_SCLK], s_lvl[IDX_VS], s_rise[IDX_DATA], s_fall[IDX_DATA],
                           s_fall[IDX_SCLK], active_flat[0*DATA_W+8 +: 4],
                           active_flat[1*DATA_W+8 +: 4], active_flat[2*DATA_W+7 +: 5]};
endmodule

// File: rtl/cfg_serial_bank_chk.sv
// Assertion checker for cfg_serial_bank, attached with bind.
module cfg_serial_bank_chk
    import cfg_bank_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic commit,
    input logic init_hit,
    input logic [NUM_SLOTS-1:0] wr_hit,
    input logic [4:0] bit_cnt,
    input logic [NUM_SLOTS*DATA_W-1:0] stage_flat,
    input logic [NUM_SLOTS*DATA_W-1:0] active_flat
);
    localparam logic [NUM_SLOTS*DATA_W-1:0] DEFS = all_defaults();

    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (active_flat != $past(active_flat)) |-> $past(commit || init_hit)); // R4
    AST_COMMIT_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(commit) |-> (active_flat == stage_flat)); // R4
    AST_INIT_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(init_hit) |-> (active_flat == DEFS && stage_flat == DEFS)); // R6
    AST_ONE_SLOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_hit)); // R3
    AST_COUNT_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 5'd17); // R8
    AST_INIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        init_hit |-> (wr_hit == '0)); // R6
endmodule

bind cfg_serial_bank cfg_serial_bank_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .init_hit    (init_hit),
    .wr_hit      (wr_hit),
    .bit_cnt     (bit_cnt),
    .stage_flat  (stage_flat),
    .active_flat (active_flat)
);

// File: tb/tb_cfg_serial_bank.sv
// Self-checking bench: sweeps gain and clamp codes, exercises edge select,
// initialization, ignored addresses, partial words and tied-strobe mode.
module tb_cfg_serial_bank;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdata = 1'b0, strobe = 1'b0, vs_reg = 1'b0, tie = 1'b0;
    logic frame_sync;
    logic [7:0]  gain_code, aux_code;
    logic [6:0]  clamp_code;
    logic [11:0] ctrl_word, test_word;
    int vectors = 0, miscompares = 0;
    logic [11:0] stg [5];
    logic [11:0] act [5];

    always #2 clk = ~clk;
    assign frame_sync = tie ? strobe : vs_reg;

    cfg_serial_bank dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_data(sdata),
        .ser_strobe(strobe), .frame_sync(frame_sync), .gain_code(gain_code),
        .aux_code(aux_code), .clamp_code(clamp_code), .ctrl_word(ctrl_word),
        .test_word(test_word)
    );

    function automatic int width_of(int s);
        return (s < 2) ? 8 : (s == 2) ? 7 : 12;
    endfunction

    function automatic int slot_of(logic [3:0] a);
        if (a <= 4'd3) return int'(a);
        if (a == 4'd15) return 4;
        return -1;
    endfunction

    task automatic set_defaults();
        for (int s = 0; s < 5; s++) begin
            stg[s] = (s == 3) ? 12'h2C4 : 12'h000;
            act[s] = stg[s];
        end
    endtask

    task automatic commit_model();
        for (int s = 0; s < 5; s++) act[s] = stg[s];
    endtask

    task automatic model_write(logic [3:0] a, logic [11:0] d);
        int s;
        if (a == 4'd4) begin
            if (d == 12'h100) set_defaults();
        end else begin
            s = slot_of(a);
            if (s >= 0) stg[s] = d & 12'((1 << width_of(s)) - 1);
        end
    endtask

    task automatic chk(string tag, string what, logic [11:0] got, logic [11:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "gain",  {4'h0, gain_code},  act[0]);
        chk(tag, "aux",   {4'h0, aux_code},   act[1]);
        chk(tag, "clamp", {5'h0, clamp_code}, act[2]);
        chk(tag, "ctrl",  ctrl_word,          act[3]);
        chk(tag, "test",  test_word,          act[4]);
    endtask

    // Sends nbits of {a,d} MSB first; bits past 16 are zero.
    task automatic send_word(logic [3:0] a, logic [11:0] d, int nbits);
        logic [15:0] w;
        w = {a, d};
        if (tie && !act[3][8]) commit_model();
        @(negedge clk) strobe = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdata = (i < 16) ? w[15-i] : 1'b0;
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
        strobe = 1'b0;
        repeat (12) @(negedge clk);
        if (nbits == 16) model_write(a, d);
        if (tie && act[3][8]) commit_model();
    endtask

    // Full sync pulse with a check after each edge.
    task automatic pulse(string tag);
        vs_reg = 1'b1;
        repeat (12) @(negedge clk);
        if (!act[3][8]) commit_model();
        check_all(tag);
        vs_reg = 1'b0;
        repeat (12) @(negedge clk);
        if (act[3][8]) commit_model();
        check_all(tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        set_defaults();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_all("R1");

        // R2 R3: gain sweep with junk in upper data bits.
        for (int v = 0; v < 256; v++) begin
            send_word(4'd0, {4'hA, v[7:0]}, 16);
            if (v % 32 == 0) check_all("R4_hold");
            pulse("R2_R3_gain");
        end
        // R3: clamp sweep, bits above 6 dropped.
        for (int v = 0; v < 128; v++) begin
            send_word(4'd2, {5'h15, v[6:0]}, 16);
            pulse("R3_clamp");
        end
        send_word(4'd1, 12'hF5A, 16);
        send_word(4'd15, 12'hABC, 16);
        send_word(4'd3, 12'h0AB, 16);
        check_all("R4_before_edge");
        pulse("R3_aux_test_ctrl");

        // R7: unused addresses.
        for (int a = 5; a < 15; a++) send_word(4'(a), 12'hFFF, 16);
        pulse("R7");

        // R6: wrong key ignored, right key resets at once and drops pending.
        send_word(4'd4, 12'h101, 16);
        pulse("R6_wrong_key");
        send_word(4'd0, 12'h055, 16);
        send_word(4'd4, 12'h100, 16);
        check_all("R6_immediate");
        pulse("R6_pending_dropped");

        // R8: short and long words.
        send_word(4'd0, 12'h0C3, 15);
        send_word(4'd0, 12'h0C3, 17);
        send_word(4'd0, 12'h0C3, 18);
        pulse("R8");

        // R9: overwrite before the edge.
        send_word(4'd0, 12'h011, 16);
        send_word(4'd0, 12'h022, 16);
        pulse("R9");

        // R5: select falling edge, then a write commits only on the fall.
        send_word(4'd3, 12'h1C4, 16);
        pulse("R5_select");
        send_word(4'd0, 12'h033, 16);
        pulse("R5_falling_only");

        // R10: strobe tied to sync with falling edge selected.
        tie = 1'b1;
        send_word(4'd0, 12'h044, 16);
        check_all("R10");
        send_word(4'd1, 12'h0E7, 16);
        check_all("R10");
        tie = 1'b0;

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule